// File: doc/BRIEF.md
# Flash Access Permission Checker

This block rules on every access request aimed at a 64 KB on-chip flash. A request names an address, an operation (read, write or erase), the requester (the debug port or running firmware), and the fetch address of the code that issued it. One cycle after the request strobe the block returns a grant flag and a code for the reason of any denial. The flash array, its timing, the debug-port protocol and the erase engine all sit outside this block.

Debug-port requests are judged per 16 KB block against two lock bytes. Each byte holds one bit per block, and a 0 bit means locked. The lock bytes are copied into the block through a load strobe after reset. Until that copy is made, the debug port gets nothing. The two lock bytes themselves sit at the top of the flash. Firmware requests ignore the lock bytes. Instead they face an access limit tied to where the requesting code runs, and they may not touch the top three addresses. A mode flag selects a separate 256-byte scratchpad instead of the main space.

Top module: `flash_access_gate`

## Requirements
- R1: `rsp_valid` equals the previous cycle's `req_valid`. When the request was granted, `rsp_grant` is 1 in the same cycle as `rsp_valid`. After a synchronous reset, `rsp_valid` and `rsp_grant` are 0 and `rsp_reason` is 0.
- R2: In the main space, a debug request to address A is judged by lock bit A[15:14]. Bit 0 covers 0x0000–0x3FFF and bit 3 covers 0xC000–0xFFFF.
- R3: `req_op` 00 is a read, 01 is a write, and 10 or 11 is an erase. A debug read uses the read-lock byte (`rd_lock_byte`). A debug write or erase uses the write-lock byte (`wr_lock_byte`). A bit value of 1 permits the operation and 0 denies it with reason 1.
- R4: Bits 7..4 of both lock bytes have no effect on any decision.
- R5: The security bytes are at 0xFFFE and 0xFFFF. When bit 3 of the write-lock byte is 0, a debug write to either security byte is granted and a debug erase of either is denied with reason 1.
- R6: Every debug request, main space or scratchpad, is denied with reason 1 from reset until the first cycle after `lock_load` has been high.
- R7: Firmware requests (`req_dbg`=0) in the main space are never denied because of the lock bytes.
- R8: A firmware request in the main space to an address of 0xFFFD or above is denied with reason 3.
- R9: Let L be `fw_limit` and B = L×256. For L≠0, a firmware request in the main space with fetch address ≥ B and target address < B is denied with reason 2. All other firmware requests below 0xFFFD are granted. L=0 turns the limit off.
- R10: When `req_scratch`=1, lock, limit and reserved-address rules do not apply. An address above 0x00FF is denied with reason 3. Any other address is granted, except for the case in R6.
- R11: Reason codes are 0 for granted, 1 for block lock, 2 for access limit and 3 for reserved address. `rsp_grant` is 1 exactly when the reason is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_load | input | 1 | Capture strobe for the two lock bytes |
| rd_lock_byte | input | 8 | Read-lock byte value to capture |
| wr_lock_byte | input | 8 | Write/erase-lock byte value to capture |
| fw_limit | input | 8 | Firmware access limit, upper address byte |
| req_valid | input | 1 | Request strobe |
| req_dbg | input | 1 | 1 = debug port, 0 = firmware |
| req_scratch | input | 1 | 1 = scratchpad space |
| req_op | input | 2 | Operation code |
| req_addr | input | 16 | Target address |
| req_pc | input | 16 | Fetch address of the requesting code |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_grant | output | 1 | Access granted |
| rsp_reason | output | 2 | Deny reason code |

## Verification
The hardest situation to reach is the interaction between the top block's write-lock bit and the security-byte rule. The same lock bit must deny ordinary writes to 0xC000–0xFFFD, grant writes to 0xFFFE/0xFFFF, and deny erases of them. All of this must hold while the other lock bits and the ignored upper nibbles take every value. The stimulus reloads the lock bytes through the capture strobe for all 256 combinations of the two low nibbles, with the upper nibbles set to opposing patterns. After each reload it sweeps a boundary-address list with every operation code. The pre-capture window is probed directly after reset, before the first load strobe.

// File: rtl/fag_pkg.sv
`timescale 1ns/1ps
package fag_pkg;
  typedef enum logic [1:0] {
    RSN_NONE  = 2'd0,
    RSN_LOCK  = 2'd1,
    RSN_LIMIT = 2'd2,
    RSN_RSVD  = 2'd3
  } reason_t;

  localparam logic [1:0] OP_READ  = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
endpackage

// File: rtl/fag_lock_store.sv
`timescale 1ns/1ps
// Holds the per-block lock bits captured from the security bytes.
module fag_lock_store #(
  parameter int LOCK_W  = 8,
  parameter int NUM_BLK = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [LOCK_W-1:0] rd_in,
  input  logic [LOCK_W-1:0] we_in,
  output logic [NUM_BLK-1:0] rd_bits,
  output logic [NUM_BLK-1:0] we_bits,
  output logic              loaded
);
  // Upper bits of each byte carry no meaning.
  logic unused_hi;
  assign unused_hi = ^{rd_in[LOCK_W-1:NUM_BLK], we_in[LOCK_W-1:NUM_BLK]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_bits <= '0;
      we_bits <= '0;
      loaded  <= 1'b0;
    end else if (load) begin
      rd_bits <= rd_in[NUM_BLK-1:0];
      we_bits <= we_in[NUM_BLK-1:0];
      loaded  <= 1'b1;
    end
  end
endmodule

// File: rtl/fag_dbg_rule.sv
`timescale 1ns/1ps
// Block-lock decision for debug-port requests in the main space.
module fag_dbg_rule
  import fag_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int NUM_BLK = 4,
  parameter int SEC_CNT = 2
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [1:0]         op,
  input  logic [NUM_BLK-1:0] rd_bits,
  input  logic [NUM_BLK-1:0] we_bits,
  input  logic               loaded,
  output reason_t            reason
);
  localparam int SEL_W = $clog2(NUM_BLK);
  localparam logic [ADDR_W-1:0] SEC_BASE = {ADDR_W{1'b1}} - ADDR_W'(SEC_CNT - 1);

  logic [NUM_BLK-1:0] blk_hit;
  for (genvar g = 0; g < NUM_BLK; g++) begin : g_hit
    assign blk_hit[g] = (addr[ADDR_W-1 -: SEL_W] == SEL_W'(g));
  end

  logic is_read, is_erase, permitted, in_sec, top_locked;
  assign is_read    = (op == OP_READ);
  assign is_erase   = op[1];
  assign permitted  = |(blk_hit & (is_read ? rd_bits : we_bits));
  assign in_sec     = (addr >= SEC_BASE);
  assign top_locked = ~we_bits[NUM_BLK-1];

  always_comb begin
    if (!loaded)
      reason = RSN_LOCK;
    else if (in_sec && top_locked && !is_read)
      reason = is_erase ? RSN_LOCK : RSN_NONE;
    else
      reason = permitted ? RSN_NONE : RSN_LOCK;
  end
endmodule

// File: rtl/fag_fw_rule.sv
`timescale 1ns/1ps
// Reserved-address and access-limit decision for firmware requests.
module fag_fw_rule
  import fag_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int LIM_W   = 8,
  parameter int RSV_CNT = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] pc,
  input  logic [LIM_W-1:0]  limit,
  output reason_t           reason
);
  localparam int SHIFT = ADDR_W - LIM_W;
  localparam logic [ADDR_W-1:0] RSV_BASE = {ADDR_W{1'b1}} - ADDR_W'(RSV_CNT - 1);

  logic [ADDR_W-1:0] bound;
  logic              lim_on, below, code_high;
  assign bound     = {limit, {SHIFT{1'b0}}};
  assign lim_on    = |limit;
  assign below     = (addr < bound);
  assign code_high = (pc >= bound);

  always_comb begin
    if (addr >= RSV_BASE)                 reason = RSN_RSVD;
    else if (lim_on && code_high && below) reason = RSN_LIMIT;
    else                                  reason = RSN_NONE;
  end
endmodule

// File: rtl/flash_access_gate.sv
`timescale 1ns/1ps
module flash_access_gate
  import fag_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int NUM_BLK = 4,
  parameter int LOCK_W  = 8,
  parameter int LIM_W   = 8,
  parameter int SCR_W   = 8,
  parameter int RSV_CNT = 3,
  parameter int SEC_CNT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lock_load,
  input  logic [LOCK_W-1:0] rd_lock_byte,
  input  logic [LOCK_W-1:0] wr_lock_byte,
  input  logic [LIM_W-1:0]  fw_limit,
  input  logic              req_valid,
  input  logic              req_dbg,
  input  logic              req_scratch,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] req_pc,
  output logic              rsp_valid,
  output logic              rsp_grant,
  output logic [1:0]        rsp_reason
);
  logic [NUM_BLK-1:0] rd_bits, we_bits;
  logic               loaded;
  reason_t            dbg_reason, fw_reason, reason_d;

  fag_lock_store #(.LOCK_W(LOCK_W), .NUM_BLK(NUM_BLK)) u_store (
    .clk(clk), .rst(rst), .load(lock_load),
    .rd_in(rd_lock_byte), .we_in(wr_lock_byte),
    .rd_bits(rd_bits), .we_bits(we_bits), .loaded(loaded)
  );

  fag_dbg_rule #(.ADDR_W(ADDR_W), .NUM_BLK(NUM_BLK), .SEC_CNT(SEC_CNT)) u_dbg (
    .addr(req_addr), .op(req_op), .rd_bits(rd_bits), .we_bits(we_bits),
    .loaded(loaded), .reason(dbg_reason)
  );

  fag_fw_rule #(.ADDR_W(ADDR_W), .LIM_W(LIM_W), .RSV_CNT(RSV_CNT)) u_fw (
    .addr(req_addr), .pc(req_pc), .limit(fw_limit), .reason(fw_reason)
  );

  // Scratchpad bypasses lock and limit rules; only its size is enforced.
  always_comb begin
    if (req_scratch) begin
      if (req_dbg && !loaded)          reason_d = RSN_LOCK;
      else if (|req_addr[ADDR_W-1:SCR_W]) reason_d = RSN_RSVD;
      else                             reason_d = RSN_NONE;
    end else if (req_dbg) begin
      reason_d = dbg_reason;
    end else begin
      reason_d = fw_reason;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_grant  <= 1'b0;
      rsp_reason <= RSN_NONE;
    end else begin
      rsp_valid  <= req_valid;
      rsp_grant  <= req_valid && (reason_d == RSN_NONE);
      rsp_reason <= req_valid ? reason_d : RSN_NONE;
    end
  end
endmodule

// File: rtl/flash_access_gate_chk.sv
`timescale 1ns/1ps
module fag_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              lock_load,
  input logic              req_valid,
  input logic              req_dbg,
  input logic              req_scratch,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_grant,
  input logic [1:0]        rsp_reason
);
  logic seen_load;
  always_ff @(posedge clk) begin
    if (rst) seen_load <= 1'b0;
    else if (lock_load) seen_load <= 1'b1;
  end

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R1
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid && !rsp_grant); // R1
  AST_GRANT_IFF_NONE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_grant == (rsp_reason == 2'd0))); // R11
  AST_DBG_BEFORE_LOAD: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_dbg && !seen_load) |=> !rsp_grant && rsp_reason == 2'd1); // R6
  AST_FW_RESERVED: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_dbg && !req_scratch && req_addr >= 16'hFFFD)
      |=> !rsp_grant && rsp_reason == 2'd3); // R8
  AST_FW_NO_LOCK_REASON: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_dbg) |=> rsp_reason != 2'd1); // R7
endmodule

bind flash_access_gate fag_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .lock_load(lock_load), .req_valid(req_valid),
  .req_dbg(req_dbg), .req_scratch(req_scratch), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_reason(rsp_reason)
);

// File: tb/flash_access_gate_tb_top.sv
`timescale 1ns/1ps
module flash_access_gate_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lock_load = 1'b0;
  logic [7:0]  rd_lock_byte = 8'h00, wr_lock_byte = 8'h00, fw_limit = 8'h00;
  logic        req_valid = 1'b0, req_dbg = 1'b0, req_scratch = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic [15:0] req_addr = 16'h0, req_pc = 16'h0;
  logic        rsp_valid, rsp_grant;
  logic [1:0]  rsp_reason;

  int checks = 0;
  int fails  = 0;
  logic loaded_b = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  flash_access_gate dut_i (
    .clk(clk), .rst(rst), .lock_load(lock_load),
    .rd_lock_byte(rd_lock_byte), .wr_lock_byte(wr_lock_byte), .fw_limit(fw_limit),
    .req_valid(req_valid), .req_dbg(req_dbg), .req_scratch(req_scratch),
    .req_op(req_op), .req_addr(req_addr), .req_pc(req_pc),
    .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_reason(rsp_reason)
  );

  logic [15:0] addrs [16] = '{16'h0000, 16'h00FF, 16'h0100, 16'h3FFF,
                              16'h4000, 16'h7FFF, 16'h8000, 16'hBFFF,
                              16'hC000, 16'hC0FF, 16'hC100, 16'hFEFF,
                              16'hFFFC, 16'hFFFD, 16'hFFFE, 16'hFFFF};

  // Expected reason code from the requirements (grant iff 0, R11).
  function automatic logic [1:0] model(input logic dbg, scr, input logic [1:0] op,
                                       input logic [15:0] addr, pc);
    logic [7:0]  sel;
    logic [16:0] bnd;
    if (dbg && !loaded_b) return 2'd1;                         // R6
    if (scr) return (addr > 16'h00FF) ? 2'd3 : 2'd0;           // R10
    if (dbg) begin
      if (op != 2'b00 && addr >= 16'hFFFE && !wr_lock_byte[3]) // R5
        return (op == 2'b01) ? 2'd0 : 2'd1;
      sel = (op == 2'b00) ? rd_lock_byte : wr_lock_byte;       // R3
      return sel[addr / 16'h4000] ? 2'd0 : 2'd1;               // R2
    end
    if (addr >= 16'hFFFD) return 2'd3;                         // R8
    bnd = 17'(fw_limit) * 17'd256;                             // R9
    if (fw_limit != 0 && 17'(pc) >= bnd && 17'(addr) < bnd) return 2'd2;
    return 2'd0;                                               // R7
  endfunction

  task automatic issue(input logic dbg, scr, input logic [1:0] op,
                       input logic [15:0] addr, pc, input string tag);
    logic [1:0] exp_r;
    exp_r = model(dbg, scr, op, addr, pc);
    @(negedge clk);
    req_valid = 1'b1; req_dbg = dbg; req_scratch = scr;
    req_op = op; req_addr = addr; req_pc = pc;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b1 || rsp_grant !== (exp_r == 2'd0) || rsp_reason !== exp_r) begin
      fails++;
      $display("FAIL %s R11 dbg=%0b scr=%0b op=%0d addr=%h pc=%h: got v=%0b g=%0b r=%0d exp v=1 g=%0b r=%0d",
               tag, dbg, scr, op, addr, pc, rsp_valid, rsp_grant, rsp_reason,
               exp_r == 2'd0, exp_r);
    end
    req_valid = 1'b0;
  endtask

  task automatic load_locks(input logic [7:0] rb, wb);
    @(negedge clk);
    rd_lock_byte = rb; wr_lock_byte = wb; lock_load = 1'b1;
    @(negedge clk);
    lock_load = 1'b0; loaded_b = 1'b1;
  endtask

  task automatic check_idle(input string tag);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_grant !== 1'b0 || rsp_reason !== 2'd0) begin
      fails++;
      $display("FAIL %s idle: got v=%0b g=%0b r=%0d exp 0 0 0", tag, rsp_valid, rsp_grant, rsp_reason);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: got running exp finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_idle("R1 reset");
    // R6: before any capture every debug request is refused.
    rd_lock_byte = 8'hFF; wr_lock_byte = 8'hFF;
    foreach (addrs[i]) issue(1'b1, 1'b0, 2'b00, addrs[i], 16'h0, "R6");
    issue(1'b1, 1'b1, 2'b01, 16'h0010, 16'h0, "R6");
    @(negedge clk);
    check_idle("R1 no request");
    // R2/R3/R4/R5: every low-nibble pair, upper nibbles opposing.
    for (int r = 0; r < 16; r++) begin
      for (int w = 0; w < 16; w++) begin
        load_locks({4'(w) ^ 4'hA, 4'(r)}, {4'(r) ^ 4'h5, 4'(w)});
        foreach (addrs[i])
          for (int op = 0; op < 4; op++)
            issue(1'b1, 1'b0, 2'(op), addrs[i],
                  16'h0, (addrs[i] >= 16'hFFFE) ? "R5" : "R2/R3/R4");
      end
    end
    // R7/R8/R9: firmware with every lock bit cleared.
    load_locks(8'h00, 8'h00);
    foreach (addrs[li]) begin
      fw_limit = (li < 4) ? 8'h00 : addrs[li][15:8] + 8'(li[0]);
      foreach (addrs[p])
        foreach (addrs[a]) begin
          issue(1'b0, 1'b0, 2'(a % 4), addrs[a], addrs[p], "R7/R8/R9");
        end
    end
    // R10: scratchpad for both requesters, limit maxed.
    fw_limit = 8'hFF;
    foreach (addrs[a])
      for (int op = 0; op < 4; op++) begin
        issue(1'b0, 1'b1, 2'(op), addrs[a], 16'hFFFF, "R10");
        issue(1'b1, 1'b1, 2'(op), addrs[a], 16'hFFFF, "R10");
      end
    @(negedge clk);
    check_idle("R1 tail");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule